// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block collects single-line interrupt requests from up to `NUM_SRC` on-chip sources, plus three external request inputs at core priority levels 1, 6 and 7. It keeps a pending register, an enable mask, an in-service register and a mode register. From these and the external inputs it drives a 3-bit priority level toward the processor core. Each on-chip source numbered n (1 to `NUM_SRC`) sits at bit n-1 of the pending, mask and in-service registers. A higher number means higher priority. The internal sources all share core level 4.

When the core acknowledges a level, the block returns an 8-bit vector one cycle later. The upper three bits come from the mode register. The lower five bits are a code: the source number for internal interrupts, 0 when a level-4 acknowledge finds nothing to serve, and fixed codes for external levels. The controller supplies an external vector only when that level's enable bit is set. A set in-service bit allows nesting: while a source is in service, only strictly higher sources may interrupt. Software uses a small word-wide read/write port. Pending and in-service bits are cleared by writing 1, which also allows pure polling with every source masked.

Top module: `prio_intc`

## Requirements
- R1: After reset, all four registers read 0, `irq_lvl_o` is 0 and `vec_vld_o` is 0.
- R2: A request on source n sets pending bit n-1 whether or not the source is enabled. A source whose mask bit is 0 never causes a level-4 request, so with every mask bit clear, software can poll the pending register.
- R3: `irq_lvl_o` is 7 if `ext_req_i[2]` is set. Otherwise it is 6 if `ext_req_i[1]` is set, then 4 if an internal request is active, then 1 if `ext_req_i[0]` is set, and 0 if none of these holds.
- R4: The cycle after `iack_i` is sampled with `iack_lvl_i`=4, `vec_vld_o` is 1 for one cycle. `vec_o[7:5]` holds mode bits [7:5], and `vec_o[4:0]` holds the number of the highest enabled pending source.
- R5: Such an acknowledge clears the winner's pending bit and sets its in-service bit.
- R6: A level-4 acknowledge with no enabled pending source returns code 00000 and leaves pending and in-service unchanged.
- R7: An internal request is active only while the highest enabled pending source number is strictly greater than the highest in-service source number (0 if none is in service).
- R8: Mode bits 0, 1 and 2 enable vectoring for external levels 1, 6 and 7, with codes `NUM_SRC`+1, +2 and +3 (29, 30, 31 by default). An acknowledge of a level that is disabled, or of any level other than 1, 4, 6 or 7, leaves `vec_vld_o` at 0.
- R9: Writing 1 to a pending bit clears it. A request arriving in the same cycle as that clear keeps the bit set.
- R10: Writing 1 to an in-service bit clears it. Writing 0 leaves it unchanged.
- R11: Register map by `reg_addr_i`:
  - 0 is mode. Only bits [7:5] and [2:0] are stored; the other bits read 0.
  - 1 is pending.
  - 2 is the enable mask, where 1 means enabled.
  - 3 is in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | NUM_SRC | Request from source n on bit n-1 |
| ext_req_i | input | 3 | External requests: bit0 level 1, bit1 level 6, bit2 level 7 |
| irq_lvl_o | output | 3 | Priority level requested from the core |
| iack_i | input | 1 | Acknowledge strobe, one cycle |
| iack_lvl_i | input | 3 | Level being acknowledged |
| vec_o | output | 8 | Vector, valid with vec_vld_o |
| vec_vld_o | output | 1 | Controller supplies the vector this cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of selected register |

## Verification
The assertions assume the core raises `iack_i` for one cycle at a time and never acknowledges while a vector is being returned. They also assume each source pulses its request rather than holding it through an acknowledge. The bench drives every acknowledge as a single-cycle strobe with idle cycles between, and pulses each source for one cycle. It also keeps software writes to the in-service register away from the cycle of an acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int VEC_W   = 8;
  localparam int CODE_W  = 5;
  localparam int HI_W    = VEC_W - CODE_W;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  localparam logic [2:0] LVL_EXT_LO  = 3'd1;
  localparam logic [2:0] LVL_INT     = 3'd4;
  localparam logic [2:0] LVL_EXT_MID = 3'd6;
  localparam logic [2:0] LVL_EXT_HI  = 3'd7;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_PEND = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_ISR  = 2'd3;

  typedef struct packed {
    logic [HI_W-1:0] hi;      // vector upper bits, stored at [7:5]
    logic [2:0]      ext_en;  // {lvl7, lvl6, lvl1}
  } mode_t;
endpackage

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N      = 28,
  parameter int CODE_W = 5
) (
  input  logic [N-1:0]      bits_i,
  output logic [CODE_W-1:0] num_o
);
  // highest set bit wins; bit i reports number i+1, none reports 0
  always_comb begin
    num_o = '0;
    for (int i = 0; i < N; i++)
      if (bits_i[i]) num_o = CODE_W'(i + 1);
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [NUM_SRC-1:0] ack_hit_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output mode_t             mode_o,
  output logic [NUM_SRC-1:0] pnd_o,
  output logic [NUM_SRC-1:0] msk_o,
  output logic [NUM_SRC-1:0] isr_o
);
  logic [NUM_SRC-1:0] wsrc;
  logic [NUM_SRC-1:0] pnd_clr, isr_clr;

  assign wsrc    = wdata_i[NUM_SRC-1:0];
  assign pnd_clr = (we_i && addr_i == A_PEND) ? wsrc : '0;
  assign isr_clr = (we_i && addr_i == A_ISR)  ? wsrc : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      pnd_o  <= '0;
      msk_o  <= '0;
      isr_o  <= '0;
    end else begin
      // new request beats clear
      pnd_o <= (pnd_o & ~(pnd_clr | ack_hit_i)) | src_req_i;
      isr_o <= (isr_o & ~isr_clr) | ack_hit_i;
      if (we_i && addr_i == A_MODE) begin
        mode_o.hi     <= wdata_i[7:5];
        mode_o.ext_en <= wdata_i[2:0];
      end
      if (we_i && addr_i == A_MASK) msk_o <= wsrc;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE: begin
        rdata_o[7:5] = mode_o.hi;
        rdata_o[2:0] = mode_o.ext_en;
      end
      A_PEND: rdata_o[NUM_SRC-1:0] = pnd_o;
      A_MASK: rdata_o[NUM_SRC-1:0] = msk_o;
      default: rdata_o[NUM_SRC-1:0] = isr_o;
    endcase
  end
endmodule

// File: rtl/intc_ack.sv
module intc_ack
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iack_i,
  input  logic [2:0]         iack_lvl_i,
  input  mode_t              mode_i,
  input  logic [CODE_W-1:0]  win_num_i,
  output logic [NUM_SRC-1:0] ack_hit_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o
);
  localparam logic [CODE_W-1:0] CODE_L1 = CODE_W'(NUM_SRC + 1);
  localparam logic [CODE_W-1:0] CODE_L6 = CODE_W'(NUM_SRC + 2);
  localparam logic [CODE_W-1:0] CODE_L7 = CODE_W'(NUM_SRC + 3);

  logic ack_int;
  assign ack_int = iack_i && (iack_lvl_i == LVL_INT);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
    assign ack_hit_o[g] = ack_int && (win_num_i == CODE_W'(g + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
    end else begin
      vec_vld_o <= 1'b0;
      if (iack_i) begin
        unique case (iack_lvl_i)
          LVL_INT: begin
            vec_vld_o <= 1'b1;
            vec_o     <= {mode_i.hi, win_num_i};
          end
          LVL_EXT_LO: if (mode_i.ext_en[0]) begin
            vec_vld_o <= 1'b1;
            vec_o     <= {mode_i.hi, CODE_L1};
          end
          LVL_EXT_MID: if (mode_i.ext_en[1]) begin
            vec_vld_o <= 1'b1;
            vec_o     <= {mode_i.hi, CODE_L6};
          end
          LVL_EXT_HI: if (mode_i.ext_en[2]) begin
            vec_vld_o <= 1'b1;
            vec_o     <= {mode_i.hi, CODE_L7};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [2:0]         ext_req_i,
  output logic [2:0]         irq_lvl_o,
  input  logic               iack_i,
  input  logic [2:0]         iack_lvl_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o
);
  mode_t              mode;
  logic [NUM_SRC-1:0] pnd_q, msk_q, isr_q, cand, ack_hit;
  logic [CODE_W-1:0]  win_num, svc_num;
  logic [HI_W-1:0]    vec_hi;
  logic               int_req;

  assign cand   = pnd_q & msk_q;
  assign vec_hi = mode.hi;

  intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i, .rst_ni, .src_req_i,
    .ack_hit_i (ack_hit),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .mode_o    (mode),
    .pnd_o     (pnd_q),
    .msk_o     (msk_q),
    .isr_o     (isr_q)
  );

  intc_prio_enc #(.N(NUM_SRC), .CODE_W(CODE_W)) u_win (
    .bits_i (cand), .num_o (win_num)
  );

  intc_prio_enc #(.N(NUM_SRC), .CODE_W(CODE_W)) u_svc (
    .bits_i (isr_q), .num_o (svc_num)
  );

  intc_ack #(.NUM_SRC(NUM_SRC)) u_ack (
    .clk_i, .rst_ni, .iack_i, .iack_lvl_i,
    .mode_i    (mode),
    .win_num_i (win_num),
    .ack_hit_o (ack_hit),
    .vec_o, .vec_vld_o
  );

  assign int_req = win_num > svc_num;

  always_comb begin
    if (ext_req_i[2])      irq_lvl_o = LVL_EXT_HI;
    else if (ext_req_i[1]) irq_lvl_o = LVL_EXT_MID;
    else if (int_req)      irq_lvl_o = LVL_INT;
    else if (ext_req_i[0]) irq_lvl_o = LVL_EXT_LO;
    else                   irq_lvl_o = 3'd0;
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 28
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               iack_i,
  input logic [2:0]         iack_lvl_i,
  input logic [2:0]         ext_req_i,
  input logic [2:0]         irq_lvl_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_vld_o,
  input logic [HI_W-1:0]    vec_hi,
  input logic [NUM_SRC-1:0] pnd_q,
  input logic [NUM_SRC-1:0] msk_q,
  input logic [NUM_SRC-1:0] isr_q
);
  a_r4_vld_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(iack_i));

  a_r4_vec_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> vec_o[VEC_W-1:CODE_W] == $past(vec_hi));

  a_r2_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_q == '0 && ext_req_i == '0) |-> irq_lvl_o == 3'd0);

  a_r3_ext7_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_i[2] |-> irq_lvl_o == LVL_EXT_HI);

  a_r5_isr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld_o && $past(iack_lvl_i) == LVL_INT && vec_o[CODE_W-1:0] != '0)
      |-> isr_q[vec_o[CODE_W-1:0] - 1'b1]);

  a_r6_err_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld_o && $past(iack_lvl_i) == LVL_INT && $past(pnd_q & msk_q) == '0)
      |-> vec_o[CODE_W-1:0] == '0);
endmodule

bind prio_intc intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i, .rst_ni, .iack_i, .iack_lvl_i, .ext_req_i, .irq_lvl_o,
  .vec_o, .vec_vld_o, .vec_hi, .pnd_q, .msk_q, .isr_q
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  localparam int N = 28;

  logic        clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic [2:0]  ext = '0, lvl = '0, irq;
  logic        iack = 0, vld, we = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_intc #(.NUM_SRC(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src), .ext_req_i(ext),
    .irq_lvl_o(irq), .iack_i(iack), .iack_lvl_i(lvl), .vec_o(vec),
    .vec_vld_o(vld), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(string r, logic [1:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(r, rdata, exp);
  endtask

  task automatic pulse(int n);
    @(negedge clk); src[n-1] = 1'b1;
    @(negedge clk); src = '0;
  endtask

  // returns {vld, vec} observed after the acknowledge edge
  task automatic ack(logic [2:0] l, output logic [8:0] res);
    @(negedge clk); iack = 1; lvl = l;
    @(negedge clk); iack = 0; lvl = '0;
    res = {vld, vec};
    @(negedge clk);
    chk("R4 vld one cycle", {31'd0, vld}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 irq", {29'd0, irq}, 0);
    chk("R1 vld", {31'd0, vld}, 0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", 2'(a), 0);
  endtask

  task automatic t_mode();
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk("R11 mode mask", 2'd0, 32'hE7);
    wr(2'd0, 32'hA0);
    rd_chk("R11 mode", 2'd0, 32'hA0);
  endtask

  task automatic t_poll();
    pulse(3);
    rd_chk("R2 pend while masked", 2'd1, 32'h4);
    chk("R2 no irq masked", {29'd0, irq}, 0);
    wr(2'd2, 32'h4);
    rd_chk("R11 mask", 2'd2, 32'h4);
    chk("R3 internal lvl", {29'd0, irq}, 4);
  endtask

  task automatic t_ack();
    logic [8:0] r;
    ack(3'd4, r);
    chk("R4 vector src3", {23'd0, r}, {23'd0, 9'h1A3});
    rd_chk("R5 pend cleared", 2'd1, 0);
    rd_chk("R5 isr set", 2'd3, 32'h4);
    chk("R7 no irq in service", {29'd0, irq}, 0);
  endtask

  task automatic t_nest();
    logic [8:0] r;
    wr(2'd2, 32'h1E);
    pulse(2);
    chk("R7 lower waits", {29'd0, irq}, 0);
    pulse(5);
    chk("R7 higher nests", {29'd0, irq}, 4);
    ack(3'd4, r);
    chk("R7 nested vector", {23'd0, r}, {23'd0, 9'h1A5});
    rd_chk("R5 isr nested", 2'd3, 32'h14);
    wr(2'd3, 32'h10);
    rd_chk("R10 isr w1c", 2'd3, 32'h4);
    chk("R7 still blocked", {29'd0, irq}, 0);
    wr(2'd3, 32'h0);
    rd_chk("R10 write 0 no effect", 2'd3, 32'h4);
    wr(2'd3, 32'h4);
    chk("R10 cleared, src2 ready", {29'd0, irq}, 4);
    ack(3'd4, r);
    chk("R4 vector src2", {23'd0, r}, {23'd0, 9'h1A2});
    wr(2'd3, 32'h2);
  endtask

  task automatic t_err();
    logic [8:0] r;
    ack(3'd4, r);
    chk("R6 error code", {23'd0, r}, {23'd0, 9'h1A0});
    rd_chk("R6 isr unchanged", 2'd3, 0);
    rd_chk("R6 pend unchanged", 2'd1, 0);
  endtask

  task automatic t_ext();
    logic [8:0] r;
    @(negedge clk); ext = 3'b100;
    #1 chk("R3 ext7", {29'd0, irq}, 7);
    ack(3'd7, r);
    chk("R8 lvl7 disabled", {31'd0, r[8]}, 0);
    wr(2'd0, 32'hA7);
    ack(3'd7, r);
    chk("R8 lvl7 vector", {23'd0, r}, {23'd0, 9'h1BF});
    ack(3'd6, r);
    chk("R8 lvl6 vector", {23'd0, r}, {23'd0, 9'h1BE});
    ack(3'd1, r);
    chk("R8 lvl1 vector", {23'd0, r}, {23'd0, 9'h1BD});
    ack(3'd3, r);
    chk("R8 other lvl", {31'd0, r[8]}, 0);
    @(negedge clk); ext = 3'b001;
    #1 chk("R3 ext1 only", {29'd0, irq}, 1);
    pulse(4);
    chk("R3 int over ext1", {29'd0, irq}, 4);
    @(negedge clk); ext = 3'b011;
    #1 chk("R3 ext6 over int", {29'd0, irq}, 6);
    @(negedge clk); ext = '0;
    wr(2'd1, 32'h8);
    wr(2'd0, 32'hA0);
  endtask

  task automatic t_w1c();
    pulse(6);
    rd_chk("R9 pend set", 2'd1, 32'h20);
    @(negedge clk); we = 1; addr = 2'd1; wdata = 32'h20; src[5] = 1'b1;
    @(negedge clk); we = 0; src = '0;
    rd_chk("R9 set beats clear", 2'd1, 32'h20);
    wr(2'd1, 32'h20);
    rd_chk("R9 cleared", 2'd1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode();
    t_poll();
    t_ack();
    t_nest();
    t_err();
    t_ext();
    t_w1c();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule